// File: doc/BRIEF.md
# Security Attribution Region Checker

This block decides, for any address, which of three security classes it belongs to: secure, non-secure, or non-secure-callable. Software fills a small table of address windows through a word-wide register port. Each window has a lower bound, an inclusive upper bound, an enable bit and a callable flag. A lookup port returns the class of an address in the same cycle.

The same classification is applied to the target of every branch that leaves non-secure code. Such a branch may enter protected code only at a callable address that the fetch path marks as holding a gateway instruction. Any other protected target is refused. A refusal raises a one-cycle violation pulse together with the offending target. That target is also kept in a register that software can read.

A strap input lets the system bypass the table. The class of the lookup address and of the branch target then comes from two external attribute inputs.

Top module: `attr_region_check`

## Requirements
- R1: After reset the unit is disabled, every table entry reads back as zero, every lookup returns secure (code 0), the violation pulse is low and the captured fault address (register word 1) reads zero.
- R2: While the unit enable (bit 0 of register word 0) is clear and the strap is low, every address is secure, even if table entries are enabled.
- R3: With the strap low, a window covers addresses from its lower bound up to its upper bound plus 31. Bounds hold bits 31:5 only, so the granule is 32 bytes. The address one below the lower bound and the address 32 above the upper bound are not covered.
- R4: With the unit enabled and the strap low, an address covered by no enabled window is secure.
- R5: Attribute codes are secure=0, callable=1, non-secure=2. A window whose callable flag is set gives code 1; otherwise it gives code 2. Where enabled windows overlap, the callable class wins over non-secure.
- R6: Table entry i sits at register word 2+2i (lower bound, bits 31:5) and word 3+2i (upper bound in bits 31:5, callable flag in bit 1, enable in bit 0). Unused bits read back as zero.
- R7: A branch from non-secure code (brFromNs=1) to a callable target whose gateway flag is set is allowed: entryOk is 1 and no violation follows.
- R8: A branch from non-secure code to a secure target, or to a callable target without the gateway flag, gives entryOk=0. On the next cycle violPulse is 1 for exactly one cycle, violAddr holds the target, and register word 1 reads that target.
- R9: A branch from secure code, or to a non-secure target, never raises a violation.
- R10: With the strap high, the table is ignored. The lookup class follows extLookupAttr and the branch class follows extTargetAttr, and code 3 is treated as secure.
- R11: Writes to register word 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| strapFixed | input | 1 | Selects external attribution instead of the table |
| extLookupAttr | input | 2 | External class of lookupAddr when the strap is high |
| extTargetAttr | input | 2 | External class of brTarget when the strap is high |
| lookupAddr | input | 32 | Address to classify |
| lookupAttr | output | 2 | Class of lookupAddr (0 secure, 1 callable, 2 non-secure) |
| brValid | input | 1 | A branch is presented for checking |
| brFromNs | input | 1 | The branch is taken from non-secure code |
| brIsGateway | input | 1 | The target holds a gateway instruction |
| brTarget | input | 32 | Branch target address |
| entryOk | output | 1 | The presented branch is legal |
| violPulse | output | 1 | One-cycle pulse, the cycle after a refused branch |
| violAddr | output | 32 | Target of the last refused branch |

## Verification
The hardest case to reach is a target that lies in an overlap of a non-secure window and a callable window. The refusal decision there depends on callable winning the overlap and also on the gateway flag. The bench builds this overlap on purpose, with one wide non-secure window and a narrow callable window inside it. It probes both edges of the inner window and offers branches with and without the gateway flag. It then keeps the table loaded and raises the strap, to show that the external classes override it completely.

// File: rtl/attr_pkg.sv
package attr_pkg;

  typedef enum logic [1:0] {
    ATTR_S   = 2'd0,
    ATTR_NSC = 2'd1,
    ATTR_NS  = 2'd2
  } attr_e;

  localparam int REG_AW    = 5;
  localparam int STB_IDX_W = REG_AW - 1;

  typedef struct packed {
    logic                 ctrlWr;
    logic                 tblWr;
    logic                 isLimit;
    logic [STB_IDX_W-1:0] idx;
  } cfg_strobe_t;

  function automatic attr_e sanitizeAttr(input logic [1:0] code);
    case (code)
      2'd1:    sanitizeAttr = ATTR_NSC;
      2'd2:    sanitizeAttr = ATTR_NS;
      default: sanitizeAttr = ATTR_S;
    endcase
  endfunction

endpackage

// File: rtl/attr_region_dp.sv
module attr_region_dp
  import attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN        = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfg_strobe_t          strb,
  input  logic [ADDR_W-1:0]    wrData,
  input  logic [REG_AW-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    rdData,
  input  logic                 strapFixed,
  input  logic [1:0]           extLookupAttr,
  input  logic [1:0]           extTargetAttr,
  input  logic [ADDR_W-1:0]    lookupAddr,
  input  logic [ADDR_W-1:0]    targetAddr,
  input  logic [ADDR_W-1:0]    faultAddr,
  output attr_e                lookupAttr,
  output attr_e                targetAttr
);

  localparam int BND_W = ADDR_W - GRAN;

  logic                   unitEn;
  logic [BND_W-1:0]       baseQ  [NUM_REGIONS];
  logic [BND_W-1:0]       limitQ [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] enQ;
  logic [NUM_REGIONS-1:0] nscQ;
  logic [NUM_REGIONS-1:0] lkHit;
  logic [NUM_REGIONS-1:0] tgHit;
  attr_e                  lkTable;
  attr_e                  tgTable;

  // Table storage, written through the control strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitEn <= 1'b0;
      enQ    <= '0;
      nscQ   <= '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
      end
    end else begin
      if (strb.ctrlWr) unitEn <= wrData[0];
      if (strb.tblWr) begin
        for (int i = 0; i < NUM_REGIONS; i++) begin
          if (strb.idx == STB_IDX_W'(i)) begin
            if (strb.isLimit) begin
              limitQ[i] <= wrData[ADDR_W-1:GRAN];
              nscQ[i]   <= wrData[1];
              enQ[i]    <= wrData[0];
            end else begin
              baseQ[i]  <= wrData[ADDR_W-1:GRAN];
            end
          end
        end
      end
    end
  end

  // Per-window comparators for both addresses
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    assign lkHit[g] = enQ[g] && (lookupAddr[ADDR_W-1:GRAN] >= baseQ[g])
                             && (lookupAddr[ADDR_W-1:GRAN] <= limitQ[g]);
    assign tgHit[g] = enQ[g] && (targetAddr[ADDR_W-1:GRAN] >= baseQ[g])
                             && (targetAddr[ADDR_W-1:GRAN] <= limitQ[g]);
  end

  // Most secure of the matching classes; callable beats non-secure
  always_comb begin
    if (!unitEn)                 lkTable = ATTR_S;
    else if (|(lkHit & nscQ))    lkTable = ATTR_NSC;
    else if (|(lkHit & ~nscQ))   lkTable = ATTR_NS;
    else                         lkTable = ATTR_S;
    if (!unitEn)                 tgTable = ATTR_S;
    else if (|(tgHit & nscQ))    tgTable = ATTR_NSC;
    else if (|(tgHit & ~nscQ))   tgTable = ATTR_NS;
    else                         tgTable = ATTR_S;
  end

  assign lookupAttr = strapFixed ? sanitizeAttr(extLookupAttr) : lkTable;
  assign targetAttr = strapFixed ? sanitizeAttr(extTargetAttr) : tgTable;

  // Register readback
  logic [REG_AW-1:0] rdOff;
  assign rdOff = rdAddr - REG_AW'(2);

  always_comb begin
    rdData = '0;
    if (rdAddr == REG_AW'(0)) begin
      rdData[0] = unitEn;
    end else if (rdAddr == REG_AW'(1)) begin
      rdData = faultAddr;
    end else begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (rdOff[REG_AW-1:1] == (REG_AW-1)'(i)) begin
          if (rdOff[0]) rdData = {limitQ[i], {(GRAN-2){1'b0}}, nscQ[i], enQ[i]};
          else          rdData = {baseQ[i], {GRAN{1'b0}}};
        end
      end
    end
  end

  // R2: a disabled unit classifies everything as secure
  p_off_secure_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strapFixed && !unitEn) |-> (lookupAttr == ATTR_S && targetAttr == ATTR_S));

  // R4: uncovered addresses stay secure
  p_nomatch_secure_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strapFixed && lkHit == '0) |-> lookupAttr == ATTR_S);

  // R5: an overlapping callable window dominates
  p_nsc_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strapFixed && unitEn && |(lkHit & nscQ)) |-> lookupAttr == ATTR_NSC);

endmodule

// File: rtl/attr_entry_ctrl.sv
module attr_entry_ctrl
  import attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output cfg_strobe_t       strb,
  input  logic              brValid,
  input  logic              brFromNs,
  input  logic              brIsGateway,
  input  logic [ADDR_W-1:0] brTarget,
  input  attr_e             targetAttr,
  output logic              entryOk,
  output logic              violPulse,
  output logic [ADDR_W-1:0] violAddr
);

  logic [REG_AW-1:0] wrOff;
  logic              faultNow;

  // Write decode into strobes; word 1 is read-only
  assign wrOff        = regAddr - REG_AW'(2);
  assign strb.ctrlWr  = regWrEn && (regAddr == REG_AW'(0));
  assign strb.tblWr   = regWrEn && (regAddr >= REG_AW'(2))
                        && (wrOff[REG_AW-1:1] < (REG_AW-1)'(NUM_REGIONS));
  assign strb.isLimit = wrOff[0];
  assign strb.idx     = wrOff[REG_AW-1:1];

  // Entry decision
  assign entryOk  = !brFromNs || (targetAttr == ATTR_NS)
                    || (targetAttr == ATTR_NSC && brIsGateway);
  assign faultNow = brValid && !entryOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violPulse <= 1'b0;
      violAddr  <= '0;
    end else begin
      violPulse <= faultNow;
      if (faultNow) violAddr <= brTarget;
    end
  end

  // R7: gateway entry at a callable target never faults
  p_gateway_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brFromNs && targetAttr == ATTR_NSC && brIsGateway) |=> !violPulse);

  // R8: a non-secure branch into secure space faults and records its target
  p_secure_tgt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brFromNs && targetAttr == ATTR_S) |=> (violPulse && violAddr == $past(brTarget)));

  // R8: the recorded address only moves together with a pulse
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !violPulse |-> $stable(violAddr));

  // R9: branches from secure code are never refused
  p_secure_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !brFromNs) |=> !violPulse);

endmodule

// File: rtl/attr_region_check.sv
module attr_region_check
  import attr_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN        = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              strapFixed,
  input  logic [1:0]        extLookupAttr,
  input  logic [1:0]        extTargetAttr,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [1:0]        lookupAttr,
  input  logic              brValid,
  input  logic              brFromNs,
  input  logic              brIsGateway,
  input  logic [ADDR_W-1:0] brTarget,
  output logic              entryOk,
  output logic              violPulse,
  output logic [ADDR_W-1:0] violAddr
);

  cfg_strobe_t strb;
  attr_e       lkAttr;
  attr_e       tgAttr;

  attr_entry_ctrl #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .strb       (strb),
    .brValid    (brValid),
    .brFromNs   (brFromNs),
    .brIsGateway(brIsGateway),
    .brTarget   (brTarget),
    .targetAttr (tgAttr),
    .entryOk    (entryOk),
    .violPulse  (violPulse),
    .violAddr   (violAddr)
  );

  attr_region_dp #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W),
    .GRAN       (GRAN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (regWrData),
    .rdAddr       (regAddr),
    .rdData       (regRdData),
    .strapFixed   (strapFixed),
    .extLookupAttr(extLookupAttr),
    .extTargetAttr(extTargetAttr),
    .lookupAddr   (lookupAddr),
    .targetAddr   (brTarget),
    .faultAddr    (violAddr),
    .lookupAttr   (lkAttr),
    .targetAttr   (tgAttr)
  );

  assign lookupAttr = lkAttr;

endmodule

// File: tb/attr_region_check_bench.sv
`timescale 1ns/1ps
module attr_region_check_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        strapFixed = 1'b0;
  logic [1:0]  extLookupAttr = '0;
  logic [1:0]  extTargetAttr = '0;
  logic [31:0] lookupAddr = '0;
  logic [1:0]  lookupAttr;
  logic        brValid = 1'b0;
  logic        brFromNs = 1'b0;
  logic        brIsGateway = 1'b0;
  logic [31:0] brTarget = '0;
  logic        entryOk;
  logic        violPulse;
  logic [31:0] violAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  attr_region_check u_attr_region_check (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strapFixed(strapFixed),
    .extLookupAttr(extLookupAttr), .extTargetAttr(extTargetAttr),
    .lookupAddr(lookupAddr), .lookupAttr(lookupAttr), .brValid(brValid),
    .brFromNs(brFromNs), .brIsGateway(brIsGateway), .brTarget(brTarget),
    .entryOk(entryOk), .violPulse(violPulse), .violAddr(violAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    regAddr = a;
    #1 chk(req, regRdData, exp);
  endtask

  task automatic lookChk(input string req, input logic [31:0] a, input logic [1:0] exp);
    lookupAddr = a;
    #1 chk(req, {30'd0, lookupAttr}, {30'd0, exp});
  endtask

  task automatic branchChk(input string req, input logic fromNs, input logic [31:0] tgt,
                           input logic gw, input logic expOk);
    @(negedge clk);
    brValid = 1'b1; brFromNs = fromNs; brTarget = tgt; brIsGateway = gw;
    #1 chk({req, " entryOk"}, {31'd0, entryOk}, {31'd0, expOk});
    @(negedge clk);
    brValid = 1'b0;
    #1 chk({req, " pulse"}, {31'd0, violPulse}, {31'd0, !expOk});
    if (!expOk) begin
      chk({req, " violAddr"}, violAddr, tgt);
      rdChk({req, " fault word"}, 5'd1, tgt);
    end
    @(negedge clk);
    #1 chk({req, " pulse width"}, {31'd0, violPulse}, 32'd0);
  endtask

  task automatic t_reset;
    rdChk("R1 ctrl", 5'd0, 32'd0);
    rdChk("R1 fault word", 5'd1, 32'd0);
    rdChk("R1 limit word", 5'd3, 32'd0);
    lookChk("R1 lookup", 32'h1000_0000, 2'd0);
    chk("R1 pulse", {31'd0, violPulse}, 32'd0);
  endtask

  task automatic t_program;
    wr(5'd2, 32'h1000_001F);  wr(5'd3, 32'h1000_0FE1);   // entry 0 non-secure
    wr(5'd4, 32'h1000_0800);  wr(5'd5, 32'h1000_08FF);   // entry 1 callable, junk bits
    wr(5'd6, 32'h2000_0000);  wr(5'd7, 32'h2000_00E3);   // entry 2 callable
    wr(5'd16, 32'h3000_0000); wr(5'd17, 32'h3000_0001);  // entry 7 single granule
    @(negedge clk);
    rdChk("R6 base masked", 5'd2, 32'h1000_0000);
    rdChk("R6 limit fields", 5'd5, 32'h1000_08E3);
    rdChk("R6 last entry", 5'd17, 32'h3000_0001);
    lookChk("R2 disabled unit", 32'h1000_0000, 2'd0);
    lookChk("R2 disabled callable", 32'h2000_0040, 2'd0);
    wr(5'd0, 32'h1);
    rdChk("R6 ctrl readback", 5'd0, 32'h1);
  endtask

  task automatic t_lookup;
    lookChk("R3 lower bound", 32'h1000_0000, 2'd2);
    lookChk("R3 below lower", 32'h0FFF_FFFF, 2'd0);
    lookChk("R3 limit plus 31", 32'h1000_0FFF, 2'd2);
    lookChk("R3 past limit", 32'h1000_1000, 2'd0);
    lookChk("R3 single top", 32'h3000_001F, 2'd2);
    lookChk("R3 single past", 32'h3000_0020, 2'd0);
    lookChk("R4 uncovered", 32'h5000_0000, 2'd0);
    lookChk("R5 overlap", 32'h1000_0850, 2'd1);
    lookChk("R5 overlap edge", 32'h1000_08FF, 2'd1);
    lookChk("R5 after inner", 32'h1000_0900, 2'd2);
  endtask

  task automatic t_entry;
    branchChk("R7 gateway entry", 1'b1, 32'h2000_0040, 1'b1, 1'b1);
    branchChk("R7 overlap gateway", 1'b1, 32'h1000_0820, 1'b1, 1'b1);
    branchChk("R8 no gateway", 1'b1, 32'h2000_0040, 1'b0, 1'b0);
    branchChk("R8 secure target", 1'b1, 32'h5000_0000, 1'b1, 1'b0);
    branchChk("R9 secure source", 1'b0, 32'h5000_0004, 1'b0, 1'b1);
    branchChk("R9 ns target", 1'b1, 32'h1000_0000, 1'b0, 1'b1);
    rdChk("R9 fault kept", 5'd1, 32'h5000_0000);
  endtask

  task automatic t_readonly;
    wr(5'd1, 32'hDEAD_BEEF);
    @(negedge clk);
    rdChk("R11 fault word", 5'd1, 32'h5000_0000);
    chk("R11 violAddr", violAddr, 32'h5000_0000);
  endtask

  task automatic t_strap;
    strapFixed = 1'b1;
    extLookupAttr = 2'd2;
    lookChk("R10 ext ns", 32'h5000_0000, 2'd2);
    lookChk("R10 table ignored", 32'h1000_0850, 2'd2);
    extLookupAttr = 2'd3;
    lookChk("R10 code 3", 32'h1000_0000, 2'd0);
    extTargetAttr = 2'd1;
    branchChk("R10 ext callable", 1'b1, 32'h5000_0100, 1'b1, 1'b1);
    extTargetAttr = 2'd0;
    branchChk("R10 ext secure", 1'b1, 32'h2000_0040, 1'b1, 1'b0);
    strapFixed = 1'b0;
    lookChk("R10 strap low", 32'h1000_0850, 2'd1);
  endtask

  task automatic t_disable;
    wr(5'd0, 32'h0);
    @(negedge clk);
    lookChk("R2 unit off", 32'h1000_0850, 2'd0);
    branchChk("R2 off entry", 1'b1, 32'h2000_0040, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_lookup();
    t_entry();
    t_readonly();
    t_strap();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule